// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This block drives one level interrupt line for a host interface that is shared by several localities. Each locality owns a private bank with an enable register and a status register. Four event kinds arrive on a single event port: command-ready, data-available, status-valid and locality-changed. Each event carries a target locality. An event is recorded only when its target bank allows it.

Software reaches the banks through a register port. The port selects the enable, status or vector register of a chosen locality. Reads work from any locality. Writes to the enable or status register take effect only from the locality that the external arbiter currently reports as active. A vector register returns a fixed interrupt number. The line stays high until a write-1-to-clear leaves the written bank's status empty.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset every status register reads 0, every enable register reads 0x0000_0008, and `irq` is low.
- R2: `evt_src` maps to status bits as follows: bit 0 is data-available (status bit 0), bit 1 is status-valid (bit 1), bit 2 is locality-changed (bit 2) and bit 3 is command-ready (bit 7). Status bit 31 of the enable register is the global enable. An event source sets its status bit, and raises `irq` one cycle after the event, only when the target bank has both the global enable and that source's enable bit set.
- R3: An event whose `evt_loc` is NUM_LOC or greater is a no-locality event. It changes no status and does not raise `irq`.
- R4: Enable and status writes are ignored when `reg_loc` differs from `act_loc`, and also when `act_loc` is NUM_LOC or greater (no active locality).
- R5: An enable write can change only bit 31, polarity bits [4:3] and source bits 7, 2, 1 and 0. All other bits always read 0.
- R6: `reg_be[k]` enables byte lane k (bits 8k+7..8k) of a write. Bytes that are not enabled keep their old value.
- R7: Writing 1 to status bit 7, 2, 1 or 0 clears that bit. Writing 0, or writing any other bit position, has no effect.
- R8: `irq` falls one cycle after a status write that clears at least one set bit and leaves the written bank's status at 0. This happens even if another bank still holds status. If status remains in the written bank, `irq` stays high.
- R9: `reg_sel` = 2 reads the VECTOR parameter in bits [3:0] and 0 in all other bits. Writes to it have no effect. `reg_sel` = 0 selects enable, 1 selects status, and 3 reads 0.
- R10: When an event sets a status bit in the same cycle as a clear of that bit, the bit ends up set and `irq` stays high.
- R11: An event changes only the bank of its target locality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_loc | input | LW | Active locality from the arbiter; NUM_LOC or above means none |
| evt_valid | input | 1 | Event strobe |
| evt_loc | input | LW | Target locality of the event |
| evt_src | input | 4 | Event sources: {command-ready, locality-changed, status-valid, data-available} |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| reg_loc | input | LW | Locality of the register access |
| reg_be | input | 4 | Byte lane enables of a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt line |

## Verification
The bench builds the block with its defaults: NUM_LOC = 5 and VECTOR = 11. This makes LW three bits wide, so the codes 5 to 7 exist as no-locality values. That lets the bench drive invalid event targets and an absent active locality directly. Five banks let the bench show isolation between banks, and show the line falling on one bank's clear while another bank still holds status.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;

  localparam logic [1:0] SEL_ENABLE = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_VECTOR = 2'd2;

  // status/enable source positions: 7 cmd-ready, 2 loc-changed, 1 sts-valid, 0 data-avail
  localparam logic [31:0] SRC_BITS    = 32'h0000_0087;
  localparam logic [31:0] EN_WRITABLE = 32'h8000_009F;
  localparam logic [31:0] EN_RESET    = 32'h0000_0008; // low-level polarity code
  localparam int          GLOBAL_BIT  = 31;

  function automatic logic [31:0] src_to_bits(input logic [3:0] s);
    return {24'b0, s[3], 4'b0, s[2:0]};
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

endpackage

// File: rtl/loc_irq_bank.sv
module loc_irq_bank
  import loc_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        st_wr,
  input  logic [31:0] lanes,
  input  logic [31:0] wdata,
  input  logic        ev_hit,
  input  logic [31:0] ev_bits,
  output logic [31:0] en_q,
  output logic [31:0] st_q,
  output logic        rec_any,
  output logic        clr_zero
);

  logic [31:0] rec, clr, en_d, st_d;
  logic        st_upd;

  always_comb begin
    rec      = (ev_hit && en_q[GLOBAL_BIT]) ? (ev_bits & en_q & SRC_BITS) : 32'b0;
    clr      = st_wr ? (wdata & lanes & SRC_BITS) : 32'b0;
    en_d     = (en_q & ~lanes) | (wdata & lanes & EN_WRITABLE);
    st_d     = (st_q & ~clr) | rec;
    st_upd   = (|rec) || (|clr);
    rec_any  = |rec;
    clr_zero = (|(clr & st_q)) && (st_d == 32'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= 32'b0;
    end else begin
      if (en_wr)  en_q <= en_d;
      if (st_upd) st_q <= st_d;
    end
  end

endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] rec_vec,
  input  logic [NUM_LOC-1:0] clrz_vec,
  output logic               irq
);

  logic irq_d, irq_upd;

  always_comb begin
    irq_upd = (|rec_vec) || (|clrz_vec);
    irq_d   = |rec_vec; // a recorded event wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_upd) irq <= irq_d;
  end

endmodule

// File: rtl/loc_irq_unit.sv
module loc_irq_unit
  import loc_irq_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter logic [3:0] VECTOR  = 4'd11,
  localparam int        LW      = $clog2(NUM_LOC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] act_loc,
  input  logic          evt_valid,
  input  logic [LW-1:0] evt_loc,
  input  logic [3:0]    evt_src,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [LW-1:0] reg_loc,
  input  logic [3:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);

  logic [31:0]        lanes, ev_bits;
  logic               wr_ok;
  logic [31:0]        en_arr [NUM_LOC];
  logic [31:0]        st_arr [NUM_LOC];
  logic [NUM_LOC-1:0] rec_vec, clrz_vec;

  always_comb begin
    lanes   = lane_mask(reg_be);
    ev_bits = src_to_bits(evt_src);
    wr_ok   = reg_wr && (act_loc < LW'(NUM_LOC)) && (reg_loc == act_loc);
  end

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_bank
    loc_irq_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (wr_ok && reg_sel == SEL_ENABLE && reg_loc == LW'(i)),
      .st_wr    (wr_ok && reg_sel == SEL_STATUS && reg_loc == LW'(i)),
      .lanes    (lanes),
      .wdata    (reg_wdata),
      .ev_hit   (evt_valid && evt_loc == LW'(i)),
      .ev_bits  (ev_bits),
      .en_q     (en_arr[i]),
      .st_q     (st_arr[i]),
      .rec_any  (rec_vec[i]),
      .clr_zero (clrz_vec[i])
    );
  end

  loc_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .rec_vec  (rec_vec),
    .clrz_vec (clrz_vec),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = 32'b0;
    if (reg_sel == SEL_VECTOR) begin
      reg_rdata = {28'b0, VECTOR};
    end else begin
      for (int i = 0; i < NUM_LOC; i++) begin
        if (reg_loc == LW'(i)) begin
          if (reg_sel == SEL_ENABLE) reg_rdata = en_arr[i];
          if (reg_sel == SEL_STATUS) reg_rdata = st_arr[i];
        end
      end
    end
  end

endmodule

// File: rtl/loc_irq_unit_chk.sv
module loc_irq_unit_chk #(
  parameter int         NUM_LOC = 5,
  parameter logic [3:0] VECTOR  = 4'd11,
  localparam int        LW      = $clog2(NUM_LOC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic [LW-1:0] evt_loc,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_rdata,
  input logic          irq
);

  // R2: the line only rises after an event strobe
  a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_valid));

  // R3: a no-locality event never raises the line
  a_r3_no_loc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_loc >= LW'(NUM_LOC) && !irq) |=> !irq);

  // R8: the line only falls after a status write
  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr && reg_sel == 2'd1));

  // R9: vector reads back the fixed number
  a_r9_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (reg_rdata == {28'b0, VECTOR}));

  // R5: no enable bit outside the writable set ever reads 1
  a_r5_enable_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> ((reg_rdata & ~32'h8000_009F) == 32'b0));

endmodule

bind loc_irq_unit loc_irq_unit_chk #(.NUM_LOC(NUM_LOC), .VECTOR(VECTOR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_loc   (evt_loc),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .irq       (irq)
);

// File: tb/loc_irq_unit_bench.sv
module loc_irq_unit_bench;
  localparam int         NUM_LOC = 5;
  localparam logic [3:0] VECTOR  = 4'd11;
  localparam int         LW      = $clog2(NUM_LOC + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] act_loc;
  logic          evt_valid;
  logic [LW-1:0] evt_loc;
  logic [3:0]    evt_src;
  logic          reg_wr;
  logic [1:0]    reg_sel;
  logic [LW-1:0] reg_loc;
  logic [3:0]    reg_be;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  loc_irq_unit #(.NUM_LOC(NUM_LOC), .VECTOR(VECTOR)) u_loc_irq_unit (
    .clk(clk), .rst_n(rst_n), .act_loc(act_loc), .evt_valid(evt_valid),
    .evt_loc(evt_loc), .evt_src(evt_src), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_loc(reg_loc), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input int loc, input logic [1:0] sel, output logic [31:0] v);
    reg_loc = LW'(loc); reg_sel = sel; #1; v = reg_rdata;
  endtask

  // drive at a negedge, return at the next negedge (after the posedge)
  task automatic cyc(input bit ev, input int eloc, input logic [3:0] src,
                     input bit wr, input int wloc, input logic [1:0] sel,
                     input logic [3:0] be, input logic [31:0] d);
    evt_valid = ev; evt_loc = LW'(eloc); evt_src = src;
    reg_wr = wr; reg_loc = LW'(wloc); reg_sel = sel; reg_be = be; reg_wdata = d;
    @(negedge clk);
    evt_valid = 0; reg_wr = 0;
  endtask

  task automatic wr(input int loc, input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    cyc(0, 0, 4'h0, 1, loc, sel, be, d);
  endtask

  task automatic ev(input int loc, input logic [3:0] src);
    cyc(1, loc, src, 0, 0, 2'd0, 4'h0, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < NUM_LOC; i++) begin
      rd(i, 2'd1, v); check("R1 status", v, 32'h0);
      rd(i, 2'd0, v); check("R1 enable", v, 32'h8);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable_gate;
    logic [31:0] v;
    act_loc = 0;
    ev(0, 4'b0001);
    rd(0, 2'd1, v); check("R2 no global/source", v, 32'h0);
    check("R2 irq stays low", {31'b0, irq}, 32'h0);
    wr(0, 2'd0, 4'hF, 32'h0000_0001);
    ev(0, 4'b0001);
    rd(0, 2'd1, v); check("R2 source only", v, 32'h0);
    wr(0, 2'd0, 4'hF, 32'h8000_0001);
    ev(0, 4'b1001);
    rd(0, 2'd1, v); check("R2 enabled source set, other not", v, 32'h1);
    check("R2 irq raised", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(0, 2'd0, 4'hF, 32'h8000_0083);
    ev(0, 4'b1010);
    rd(0, 2'd1, v); check("R2 cmd-ready at bit7", v, 32'h83);
    wr(0, 2'd1, 4'hF, 32'hFFFF_FF78);
    rd(0, 2'd1, v); check("R7 unsupported bits no clear", v, 32'h83);
    wr(0, 2'd1, 4'hF, 32'h0000_0002);
    rd(0, 2'd1, v); check("R7 clear one bit", v, 32'h81);
    check("R8 irq held while status left", {31'b0, irq}, 32'h1);
    wr(0, 2'd1, 4'hF, 32'h0000_0081);
    rd(0, 2'd1, v); check("R7 cleared", v, 32'h0);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_bad_loc;
    logic [31:0] v;
    for (int l = NUM_LOC; l < (1 << LW); l++) ev(l, 4'hF);
    check("R3 irq unchanged", {31'b0, irq}, 32'h0);
    rd(0, 2'd1, v); check("R3 bank0 untouched", v, 32'h0);
  endtask

  task automatic t_inactive;
    logic [31:0] v;
    act_loc = 0;
    wr(1, 2'd0, 4'hF, 32'h8000_009F);
    rd(1, 2'd0, v); check("R4 non-active enable write", v, 32'h8);
    act_loc = LW'(7);
    wr(0, 2'd0, 4'hF, 32'h0000_0000);
    rd(0, 2'd0, v); check("R4 no active locality", v, 32'h8000_0083);
  endtask

  task automatic t_mask_lanes;
    logic [31:0] v;
    act_loc = 1;
    wr(1, 2'd0, 4'hF, 32'hFFFF_FFFF);
    rd(1, 2'd0, v); check("R5 writable bits only", v, 32'h8000_009F);
    wr(1, 2'd0, 4'b0001, 32'h0);
    rd(1, 2'd0, v); check("R6 lane0 only", v, 32'h8000_0000);
    wr(1, 2'd0, 4'b0001, 32'hFFFF_FFFF);
    wr(1, 2'd0, 4'b1000, 32'h0);
    rd(1, 2'd0, v); check("R6 lane3 only", v, 32'h0000_009F);
    wr(1, 2'd0, 4'b1000, 32'h8000_0000);
  endtask

  task automatic t_vector;
    logic [31:0] v;
    wr(1, 2'd2, 4'hF, 32'h0000_0003);
    rd(1, 2'd2, v); check("R9 vector fixed", v, {28'b0, VECTOR});
    rd(1, 2'd3, v); check("R9 unused select", v, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    act_loc = 1;
    ev(1, 4'b0001);
    cyc(1, 1, 4'b0001, 1, 1, 2'd1, 4'hF, 32'h1);
    rd(1, 2'd1, v); check("R10 set beats clear", v, 32'h1);
    check("R10 irq kept", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_isolation;
    logic [31:0] v;
    act_loc = 2;
    wr(2, 2'd0, 4'hF, 32'h8000_0004);
    ev(2, 4'b0100);
    rd(2, 2'd1, v); check("R11 target bank", v, 32'h4);
    rd(1, 2'd1, v); check("R11 other bank kept", v, 32'h1);
    rd(3, 2'd1, v); check("R11 idle bank", v, 32'h0);
    wr(2, 2'd1, 4'hF, 32'h4);
    check("R8 drops on written bank empty", {31'b0, irq}, 32'h0);
    rd(1, 2'd1, v); check("R8 other bank still set", v, 32'h1);
  endtask

  initial begin
    rst_n = 0; act_loc = LW'(7); evt_valid = 0; evt_loc = '0; evt_src = '0;
    reg_wr = 0; reg_sel = '0; reg_loc = '0; reg_be = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_enable_gate;
    t_w1c;
    t_bad_loc;
    t_inactive;
    t_mask_lanes;
    t_vector;
    t_set_wins;
    t_isolation;
    done = 1;
  end

  initial begin : watchdog
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule